// File: doc/BRIEF.md
# Interval Timer with Auto-Reload

This block is a countdown timer that software controls through one bus register on a Wishbone-style slave port. A single write does two things: it sets the start value and it chooses whether the timer stops at zero or reloads and runs again. While the run-enable input is high, the count drops by one on each clock. When it passes from one to zero the block raises a single-clock expiry pulse. In one-shot mode the count then stays at zero. In periodic mode it reloads the written value and keeps counting.

The run-enable input is meant to be pulled low whenever the processor is halted, so that time measured by the timer freezes with the processor. The expiry pulse can be routed to an interrupt line, or to a reset request so that the block acts as a watchdog. A read returns the live count together with the mode bit. Every access is acknowledged one clock after its strobe and is never stalled.

Top module: `interval_timer`

## Requirements
- R1: After reset the count is zero, the mode is one-shot, and `wb_ack` and `expire` are low. A read then returns 0. A reset asserted while counting clears the count.
- R2: A write (`wb_cyc`, `wb_stb` and `wb_we` high) takes bit 31 as the mode (1 = periodic, 0 = one-shot) and bits 30:0 as the start and reload value. The count takes this value on the clock edge that accepts the write, and the write takes priority over a decrement in that cycle.
- R3: On each clock edge where `run_en` is high and the count is nonzero, the count falls by exactly one. The one exception is the edge that takes the count from one to zero.
- R4: While `run_en` is low, the count does not change and `expire` stays low.
- R5: In one-shot mode, the count stays at zero once it gets there and no further expiry occurs.
- R6: In periodic mode, on the edge where the count would go from one to zero, it reloads the last written value instead. A reload value of 1 therefore expires on every enabled clock.
- R7: `expire` is high for exactly one clock after each edge on which an enabled count of one reaches zero or reloads, and at no other time.
- R8: Writing a value whose bits 30:0 are zero stops the timer, and no expiry follows, whatever the mode bit says.
- R9: A read returns on `wb_rdata`, together with its `wb_ack`, the mode in bit 31 and the count in bits 30:0, as they were in the cycle the strobe was presented.
- R10: `wb_ack` is high in the cycle after each cycle with `wb_cyc` and `wb_stb` both high, and low otherwise. `wb_stall` is always low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Count enable; low while the processor is halted |
| wb_cyc | input | 1 | Bus cycle valid |
| wb_stb | input | 1 | Access strobe |
| wb_we | input | 1 | Write when high, read when low |
| wb_wdata | input | DATA_W | Write data: bit 31 mode, bits 30:0 start value |
| wb_ack | output | 1 | Acknowledge, one clock after the strobe |
| wb_stall | output | 1 | Always low |
| wb_rdata | output | DATA_W | Mode and count captured in the strobe cycle |
| expire | output | 1 | One-clock expiry pulse (interrupt or reset request) |

## Verification
If the count register held a wrong value, the next read would show it. The expiry pulse would also arrive a number of enabled clocks early or late that equals the error, so the fault is visible within one timer period. A lost or wrong mode bit shows in bit 31 of the next read, and in periodic runs it shows as a missing second expiry. A stuck enable gate shows in a read taken after a frozen interval, and a broken acknowledge path shows within one clock of any strobe.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   typedef enum logic {
      TMR_ONE_SHOT = 1'b0,
      TMR_PERIODIC = 1'b1
   } tmr_mode_e;

   localparam int unsigned TMR_MIN_DATA_W = 2;
endpackage

// File: rtl/tmr_bus_port.sv
module tmr_bus_port #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cyc,
   input  logic              stb,
   input  logic              we,
   input  logic [DATA_W-1:0] snap,
   output logic              wr_en,
   output logic              ack,
   output logic [DATA_W-1:0] rdata
);
   logic access;

   assign access = cyc && stb;
   assign wr_en  = access && we;

   always_ff @(posedge clk) begin
      if (rst) begin
         ack   <= 1'b0;
         rdata <= '0;
      end else begin
         ack <= access;
         if (access)
            rdata <= snap;
      end
   end
endmodule

// File: rtl/tmr_reload_reg.sv
module tmr_reload_reg
   import tmr_pkg::*;
#(
   parameter int unsigned CNT_W = 31
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_en,
   input  logic             wr_mode,
   input  logic [CNT_W-1:0] wr_val,
   output tmr_mode_e        mode_q,
   output logic [CNT_W-1:0] reload_q
);
   always_ff @(posedge clk) begin
      if (rst) begin
         mode_q   <= TMR_ONE_SHOT;
         reload_q <= '0;
      end else if (wr_en) begin
         mode_q   <= tmr_mode_e'(wr_mode);
         reload_q <= wr_val;
      end
   end
endmodule

// File: rtl/tmr_down_counter.sv
module tmr_down_counter #(
   parameter int unsigned CNT_W = 31
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             run_en,
   input  logic             periodic,
   input  logic [CNT_W-1:0] reload_val,
   output logic [CNT_W-1:0] cnt_q,
   output logic             expire_q
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic active;
   logic at_one;

   assign active = run_en && (cnt_q != '0);
   assign at_one = (cnt_q == ONE);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q    <= '0;
         expire_q <= 1'b0;
      end else begin
         expire_q <= 1'b0;
         if (load) begin
            cnt_q <= load_val;
         end else if (active) begin
            if (at_one) begin
               expire_q <= 1'b1;
               cnt_q    <= periodic ? reload_val : '0;
            end else begin
               cnt_q <= cnt_q - ONE;
            end
         end
      end
   end
endmodule

// File: rtl/interval_timer.sv
module interval_timer
   import tmr_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              run_en,
   input  logic              wb_cyc,
   input  logic              wb_stb,
   input  logic              wb_we,
   input  logic [DATA_W-1:0] wb_wdata,
   output logic              wb_ack,
   output logic              wb_stall,
   output logic [DATA_W-1:0] wb_rdata,
   output logic              expire
);
   localparam int unsigned CNT_W    = DATA_W - 1;
   localparam int unsigned MODE_BIT = DATA_W - 1;

   generate
      if (DATA_W < TMR_MIN_DATA_W) begin : g_bad_width
         $error("interval_timer: DATA_W must be at least 2");
      end
   endgenerate

   logic             wr_en;
   tmr_mode_e        mode_q;
   logic [CNT_W-1:0] reload_q;
   logic [CNT_W-1:0] cnt_q;
   logic [DATA_W-1:0] snap;

   assign snap     = {mode_q == TMR_PERIODIC, cnt_q};
   assign wb_stall = 1'b0;

   tmr_bus_port #(.DATA_W(DATA_W)) u_port (
      .clk   (clk),
      .rst   (rst),
      .cyc   (wb_cyc),
      .stb   (wb_stb),
      .we    (wb_we),
      .snap  (snap),
      .wr_en (wr_en),
      .ack   (wb_ack),
      .rdata (wb_rdata)
   );

   tmr_reload_reg #(.CNT_W(CNT_W)) u_reload (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (wr_en),
      .wr_mode  (wb_wdata[MODE_BIT]),
      .wr_val   (wb_wdata[CNT_W-1:0]),
      .mode_q   (mode_q),
      .reload_q (reload_q)
   );

   tmr_down_counter #(.CNT_W(CNT_W)) u_count (
      .clk        (clk),
      .rst        (rst),
      .load       (wr_en),
      .load_val   (wb_wdata[CNT_W-1:0]),
      .run_en     (run_en),
      .periodic   (mode_q == TMR_PERIODIC),
      .reload_val (reload_q),
      .cnt_q      (cnt_q),
      .expire_q   (expire)
   );
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
   parameter int unsigned DATA_W = 32
) (
   input logic              clk,
   input logic              rst,
   input logic              run_en,
   input logic              wb_cyc,
   input logic              wb_stb,
   input logic              wb_we,
   input logic [DATA_W-1:0] wb_wdata,
   input logic              wb_ack,
   input logic              expire,
   input logic [DATA_W-2:0] cnt,
   input logic              periodic
);
   localparam int unsigned CNT_W = DATA_W - 1;
   logic wr;
   assign wr = wb_cyc && wb_stb && wb_we;

   assert_ack_follows_R10: assert property (@(posedge clk) disable iff (rst)
      (wb_cyc && wb_stb) |=> wb_ack);
   assert_no_spurious_ack_R10: assert property (@(posedge clk) disable iff (rst)
      !(wb_cyc && wb_stb) |=> !wb_ack);
   assert_write_loads_R2: assert property (@(posedge clk) disable iff (rst)
      wr |=> (cnt == $past(wb_wdata[CNT_W-1:0])));
   assert_frozen_R4: assert property (@(posedge clk) disable iff (rst)
      (!run_en && !wr) |=> ($stable(cnt) && !expire));
   assert_decrement_R3: assert property (@(posedge clk) disable iff (rst)
      (run_en && !wr && cnt > CNT_W'(1)) |=> (cnt == $past(cnt) - CNT_W'(1)));
   assert_oneshot_stop_R5: assert property (@(posedge clk) disable iff (rst)
      (!periodic && cnt == '0 && !wr) |=> (cnt == '0 && !expire));
   assert_expire_cause_R7: assert property (@(posedge clk) disable iff (rst)
      expire |-> ($past(cnt) == CNT_W'(1) && $past(run_en) && !$past(wr)));
   assert_reload_R6: assert property (@(posedge clk) disable iff (rst)
      (periodic && run_en && !wr && cnt == CNT_W'(1)) |=> (expire && cnt != '0));
endmodule

bind interval_timer tmr_checker #(.DATA_W(DATA_W)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .run_en   (run_en),
   .wb_cyc   (wb_cyc),
   .wb_stb   (wb_stb),
   .wb_we    (wb_we),
   .wb_wdata (wb_wdata),
   .wb_ack   (wb_ack),
   .expire   (expire),
   .cnt      (cnt_q),
   .periodic (mode_q == tmr_pkg::TMR_PERIODIC)
);

// File: tb/sim_interval_timer.sv
`timescale 1ns/1ps
module sim_interval_timer;
   localparam int NV = 8;
   localparam logic        V_MODE [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0};
   localparam int unsigned V_START[NV] = '{5, 5, 5, 4, 4, 1, 7, 1};
   localparam int unsigned V_STEPS[NV] = '{3, 5, 9, 4, 11, 6, 2, 1};

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        run_en = 1'b0;
   logic        wb_cyc = 1'b0, wb_stb = 1'b0, wb_we = 1'b0;
   logic [31:0] wb_wdata = '0;
   logic        wb_ack, wb_stall, expire;
   logic [31:0] wb_rdata;
   int          n_chk = 0, n_bad = 0;

   always #4 clk = ~clk;

   interval_timer u0 (
      .clk(clk), .rst(rst), .run_en(run_en), .wb_cyc(wb_cyc), .wb_stb(wb_stb),
      .wb_we(wb_we), .wb_wdata(wb_wdata), .wb_ack(wb_ack), .wb_stall(wb_stall),
      .wb_rdata(wb_rdata), .expire(expire)
   );

   task automatic check(input string req, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [31:0] d);
      wb_cyc = 1'b1; wb_stb = 1'b1; wb_we = 1'b1; wb_wdata = d;
      @(posedge clk); @(negedge clk);
      check("R10 write ack", wb_ack, 1);
      wb_cyc = 1'b0; wb_stb = 1'b0; wb_we = 1'b0;
   endtask

   task automatic bus_read(output logic [31:0] d);
      wb_cyc = 1'b1; wb_stb = 1'b1; wb_we = 1'b0;
      @(posedge clk); @(negedge clk);
      check("R10 read ack", wb_ack, 1);
      d = wb_rdata;
      wb_cyc = 1'b0; wb_stb = 1'b0;
   endtask

   task automatic run(input int n, output int pulses, output int first_at);
      pulses = 0; first_at = -1;
      run_en = 1'b1;
      for (int i = 1; i <= n; i++) begin
         @(posedge clk); @(negedge clk);
         if (expire) begin
            if (first_at < 0) first_at = i;
            pulses++;
         end
         check("R10 stall low", wb_stall, 0);
      end
      run_en = 1'b0;
   endtask

   function automatic int unsigned exp_cnt(logic m, int unsigned s, int unsigned n);
      if (s == 0) return 0;
      if (n < s) return s - n;
      return m ? (s - (n % s)) : 0;
   endfunction

   function automatic int exp_pulses(logic m, int unsigned s, int unsigned n);
      if (s == 0 || n < s) return 0;
      return m ? int'(n / s) : 1;
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] rd;
      int p, f;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R1: reset state
      check("R1 ack idle", wb_ack, 0);
      check("R1 expire idle", expire, 0);
      bus_read(rd);
      check("R1 read after reset", rd, 0);

      // Table walk: R3 R5 R6 R7 R9
      for (int v = 0; v < NV; v++) begin
         bus_write({V_MODE[v], 31'(V_START[v])});
         run(V_STEPS[v], p, f);
         check("R7 pulse count", p, exp_pulses(V_MODE[v], V_START[v], V_STEPS[v]));
         bus_read(rd);
         check("R3 R5 R6 R9 read", rd,
               {V_MODE[v], 31'(exp_cnt(V_MODE[v], V_START[v], V_STEPS[v]))});
      end

      // R7: pulse arrives exactly at the step reaching zero, one clock wide
      bus_write({1'b0, 31'd3});
      run(10, p, f);
      check("R7 pulse step", f, 3);
      check("R7 single pulse", p, 1);

      // R4: enable low freezes the count
      bus_write({1'b0, 31'd10});
      p = 0;
      for (int i = 0; i < 6; i++) begin
         @(posedge clk); @(negedge clk);
         if (expire) p++;
      end
      check("R4 no expire frozen", p, 0);
      bus_read(rd);
      check("R4 frozen count", rd, 32'd10);

      // R8: zero value stops the timer even in periodic mode
      bus_write(32'h8000_0000);
      run(5, p, f);
      check("R8 no expire", p, 0);
      bus_read(rd);
      check("R8 count zero", rd, 32'h8000_0000);

      // R2: write wins over a decrement in the same cycle
      bus_write({1'b0, 31'd20});
      run(5, p, f);
      run_en = 1'b1;
      bus_write({1'b1, 31'd9});
      run_en = 1'b0;
      bus_read(rd);
      check("R2 write priority", rd, {1'b1, 31'd9});

      // R9: read captures the value in its strobe cycle while counting
      run_en = 1'b1;
      bus_read(rd);
      run_en = 1'b0;
      check("R9 snapshot", rd, {1'b1, 31'd9});

      // R10: cyc without stb is not acknowledged
      wb_cyc = 1'b1;
      @(posedge clk); @(negedge clk);
      check("R10 no ack without stb", wb_ack, 0);
      wb_cyc = 1'b0;

      // R1: reset while counting
      bus_write({1'b1, 31'd50});
      run(5, p, f);
      rst = 1'b1;
      @(posedge clk); @(negedge clk);
      rst = 1'b0;
      bus_read(rd);
      check("R1 reset mid count", rd, 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule